// File: doc/BRIEF.md
# Oscillator Frequency Error Counter

This block measures how far a local oscillator is from its target frequency. It runs in the clock domain of the oscillator being measured and compares it with a periodic reference pulse (SYNC). Each accepted SYNC reloads a programmed tick count, and the counter then steps down toward zero. If the oscillator is exactly on frequency, the next SYNC arrives just as the count reaches zero. A slow oscillator has ticks left over when SYNC arrives. A fast oscillator passes zero, turns around and counts the surplus upward. For a 48 MHz oscillator against a 1 kHz reference, the reload is 47999.

On every accepted SYNC the block captures the count together with its direction, which gives a signed frequency error: down means slow, up means fast. It also raises a one-cycle expected-sync strobe when the count reaches zero. The upward count is limited to 128 times an 8-bit error limit. When it reaches that ceiling the counter parks, raises a missed-sync strobe once, and waits for the next SYNC. The capture output is a one-cycle valid strobe with no ready signal and no back-pressure. A consumer must take `cap_value` and `cap_dir_down` in the cycle `cap_valid` is high, and they hold until the next capture.

Top module: `freq_err_counter`

## Requirements
- R1: After reset the counter is parked. `cap_value` is 0, `cap_dir_down` is 0, and no strobe is raised until the first accepted SYNC.
- R2: A SYNC sampled high while `enable` is high is accepted. On that edge the counter loads `reload_val` and counts down, and `cap_valid` is high for exactly the following cycle.
- R3: On an accepted SYNC the count held before that edge is presented on `cap_value`. `cap_dir_down` is 1 if the counter was counting down and 0 if it was counting up. Both hold until the next accepted SYNC.
- R4: With reload R, let R' = max(R,1). `esync_pulse` is high for one cycle after the R'-th enabled edge following the load. From then on the counter counts up from 0. A reload of 0 behaves like a reload of 1.
- R5: In the upward phase the count stops at OUTRANGE = 128 × `err_limit`. `miss_pulse` is high for one cycle after enabled edge R'+OUTRANGE+1. The count then stays frozen, with no further strobe, until an accepted SYNC.
- R6: While `enable` is low the count does not change, SYNC is ignored (no capture, no reload), and no strobe is raised.
- R7: An accepted SYNC takes priority: on its edge neither `esync_pulse` nor `miss_pulse` is raised. At most one of `cap_valid`, `esync_pulse` and `miss_pulse` is high in any cycle.
- R8: The full 16-bit range works. A reload of 65535 is counted from the top, and a limit of 255 gives an OUTRANGE of 32640.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the oscillator under measurement |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counter enable; when low, the counter freezes and SYNC is ignored |
| sync_pulse | input | 1 | Single-cycle reference event, already synchronised and filtered |
| reload_val | input | 16 | Value loaded on each accepted SYNC |
| err_limit | input | 8 | Error limit; the upward ceiling is 128 times this value |
| cap_value | output | 16 | Count captured at the last accepted SYNC |
| cap_dir_down | output | 1 | Direction captured with `cap_value` (1 = down, slow oscillator) |
| cap_valid | output | 1 | One-cycle strobe marking a new capture |
| esync_pulse | output | 1 | One-cycle strobe when the count reaches zero |
| miss_pulse | output | 1 | One-cycle strobe when the count parks at the ceiling |

## Verification
The embedded properties assume that `err_limit` does not change between two accepted SYNC events. If the limit were lowered during the upward phase, the count could sit above the new ceiling. They also assume that `sync_pulse` is a clean synchronous level sampled on the clock. The stimulus changes `reload_val` and `err_limit` only just before a loading SYNC. It drives all inputs on the falling edge, so every pulse is seen by exactly one rising edge. It sweeps each SYNC spacing from one cycle up to past the ceiling, for small reloads and limits of 0 and 1.

// File: rtl/fec_pkg.sv
package fec_pkg;
  // Count direction; the encoding doubles as the captured direction bit.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/fec_limit.sv
module fec_limit #(
  parameter int CNT_W = 16,
  parameter int LIM_W = 8,
  parameter int SHIFT = 7
) (
  input  logic [LIM_W-1:0] limit,
  output logic [CNT_W-1:0] ceiling
);
  localparam int PROD_W = LIM_W + SHIFT;

  logic [PROD_W-1:0] prod;
  assign prod = {limit, {SHIFT{1'b0}}};

  generate
    if (PROD_W <= CNT_W) begin : g_fit
      assign ceiling = CNT_W'(prod);
    end else begin : g_sat
      assign ceiling = (|prod[PROD_W-1:CNT_W]) ? '1 : prod[CNT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fec_core.sv
module fec_core
  import fec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] ceiling,
  output logic [CNT_W-1:0] cnt_o,
  output dir_e             dir_o,
  output logic             esync_o,
  output logic             miss_o
);
  logic [CNT_W-1:0] cnt;
  dir_e             dir;
  logic             parked;
  logic             take;

  assign take = en && sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      dir     <= DIR_UP;
      parked  <= 1'b1;
      esync_o <= 1'b0;
      miss_o  <= 1'b0;
    end else begin
      esync_o <= 1'b0;
      miss_o  <= 1'b0;
      if (take) begin
        cnt    <= reload;
        dir    <= DIR_DOWN;
        parked <= 1'b0;
      end else if (en && !parked) begin
        if (dir == DIR_DOWN) begin
          if (cnt <= CNT_W'(1)) begin
            cnt     <= '0;
            dir     <= DIR_UP;
            esync_o <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end else if (cnt >= ceiling) begin
          parked <= 1'b1;
          miss_o <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign cnt_o = cnt;
  assign dir_o = dir;

  // R5: once parked, the count holds until a SYNC is accepted
  a_r5_hold_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !take) |=> $stable(cnt));
  // R5: the upward phase never passes the ceiling
  a_r5_under_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_UP) |-> (cnt <= ceiling));
  // R5: the missed-sync strobe is never repeated in the next cycle
  a_r5_miss_once: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |=> !miss_o);
  // R4: the expected-sync strobe coincides with a zero count in the up phase
  a_r4_esync_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    esync_o |-> (cnt == '0 && dir == DIR_UP));
  // R6: a disabled edge changes nothing
  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && !esync_o && !miss_o));
endmodule

// File: rtl/fec_capture.sv
module fec_capture
  import fec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CNT_W-1:0] cnt,
  input  dir_e             dir,
  output logic [CNT_W-1:0] value,
  output logic             dir_down,
  output logic             valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value    <= '0;
      dir_down <= 1'b0;
      valid    <= 1'b0;
    end else begin
      valid <= take;
      if (take) begin
        value    <= cnt;
        dir_down <= (dir == DIR_DOWN);
      end
    end
  end

  // R3: the captured result holds between accepted SYNC events
  a_r3_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(value) && $stable(dir_down) && !valid));
endmodule

// File: rtl/freq_err_counter.sv
module freq_err_counter
  import fec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LIM_W       = 8,
  parameter int RANGE_SHIFT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sync_pulse,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [LIM_W-1:0] err_limit,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_dir_down,
  output logic             cap_valid,
  output logic             esync_pulse,
  output logic             miss_pulse
);
  logic [CNT_W-1:0] ceiling;
  logic [CNT_W-1:0] cnt;
  dir_e             dir;
  logic             take;

  assign take = enable && sync_pulse;

  fec_limit #(.CNT_W(CNT_W), .LIM_W(LIM_W), .SHIFT(RANGE_SHIFT)) u_limit (
    .limit   (err_limit),
    .ceiling (ceiling)
  );

  fec_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .sync    (sync_pulse),
    .reload  (reload_val),
    .ceiling (ceiling),
    .cnt_o   (cnt),
    .dir_o   (dir),
    .esync_o (esync_pulse),
    .miss_o  (miss_pulse)
  );

  fec_capture #(.CNT_W(CNT_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .cnt      (cnt),
    .dir      (dir),
    .value    (cap_value),
    .dir_down (cap_dir_down),
    .valid    (cap_valid)
  );

  // R7: capture, expected-sync and missed-sync strobes are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_valid, esync_pulse, miss_pulse}));
  // R2: a capture is reported only after an accepted SYNC
  a_r2_valid_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cap_valid && !esync_pulse && !miss_pulse));
endmodule

// File: tb/test_freq_err_counter.sv
module test_freq_err_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        sync_pulse = 1'b0;
  logic [15:0] reload_val = 16'd0;
  logic [7:0]  err_limit = 8'd0;
  logic [15:0] cap_value;
  logic        cap_dir_down;
  logic        cap_valid;
  logic        esync_pulse;
  logic        miss_pulse;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  freq_err_counter i_freq_err_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sync_pulse   (sync_pulse),
    .reload_val   (reload_val),
    .err_limit    (err_limit),
    .cap_value    (cap_value),
    .cap_dir_down (cap_dir_down),
    .cap_valid    (cap_valid),
    .esync_pulse  (esync_pulse),
    .miss_pulse   (miss_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Accepted SYNC that loads reload r with limit l; returns at the next falling edge.
  task automatic load(input int r, input int l);
    reload_val = 16'(r);
    err_limit  = 8'(l);
    sync_pulse = 1'b1;
    @(negedge clk);
    sync_pulse = 1'b0;
  endtask

  // n enabled edges since the load; the n-th carries the next SYNC.
  task automatic interval(input int n, input int r, input int o);
    int rp;
    int k;
    int es_cnt, es_at, ms_cnt, ms_at, cv_cnt;
    int exp_val, exp_dir;
    rp = (r < 1) ? 1 : r;
    es_cnt = 0; es_at = 0; ms_cnt = 0; ms_at = 0; cv_cnt = 0;
    for (int i = 1; i <= n; i++) begin
      if (i == n) sync_pulse = 1'b1;
      @(negedge clk);
      sync_pulse = 1'b0;
      if (i < n) begin
        if (esync_pulse) begin es_cnt++; es_at = i; end
        if (miss_pulse)  begin ms_cnt++; ms_at = i; end
        if (cap_valid)   cv_cnt++;
      end else begin
        chk("R2 cap_valid on sync", int'(cap_valid), 1);
        chk("R7 no event on sync edge", int'(esync_pulse) + int'(miss_pulse), 0);
        k = n - 1;
        if (k < rp) begin exp_val = r - k; exp_dir = 1; end
        else begin
          exp_val = (k - rp < o) ? (k - rp) : o;
          exp_dir = 0;
        end
        chk("R3 cap_value", int'(cap_value), exp_val);
        chk("R3 cap_dir_down", int'(cap_dir_down), exp_dir);
      end
    end
    chk("R2 no stray cap_valid", cv_cnt, 0);
    chk("R4 esync count", es_cnt, (rp < n) ? 1 : 0);
    if (rp < n) chk("R4 esync cycle", es_at, rp);
    chk("R5 miss count", ms_cnt, (rp + o + 1 < n) ? 1 : 0);
    if (rp + o + 1 < n) chk("R5 miss cycle", ms_at, rp + o + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL timeout watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int rl [4] = '{0, 1, 2, 5};
    int lm [2] = '{0, 1};
    int strobes;
    repeat (3) @(negedge clk);
    rst_n  = 1'b1;
    enable = 1'b1;
    // R1: parked after reset, no strobes
    strobes = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      strobes += int'(esync_pulse) + int'(miss_pulse) + int'(cap_valid);
    end
    chk("R1 no strobes after reset", strobes, 0);
    chk("R1 cap_value reset", int'(cap_value), 0);
    chk("R1 cap_dir_down reset", int'(cap_dir_down), 0);

    // R3 R4 R5 R7: sweep every SYNC spacing for small reloads and limits
    foreach (rl[a]) begin
      foreach (lm[b]) begin
        int rp;
        int o;
        rp = (rl[a] < 1) ? 1 : rl[a];
        o  = lm[b] * 128;
        load(rl[a], lm[b]);
        for (int n = 1; n <= rp + o + 3; n++) interval(n, rl[a], o);
      end
    end

    // R6: disabled edges freeze the count and ignore SYNC
    load(10, 1);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    sync_pulse = 1'b1;
    @(negedge clk);
    sync_pulse = 1'b0;
    chk("R6 sync ignored while disabled", int'(cap_valid), 0);
    strobes = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      strobes += int'(esync_pulse) + int'(miss_pulse) + int'(cap_valid);
    end
    chk("R6 no strobes while disabled", strobes, 0);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    sync_pulse = 1'b1;
    @(negedge clk);
    sync_pulse = 1'b0;
    chk("R6 count frozen while disabled", int'(cap_value), 5);
    chk("R6 direction after freeze", int'(cap_dir_down), 1);

    // R8: full-width reload and largest limit
    load(65535, 3);
    interval(3, 65535, 384);
    load(2, 255);
    interval(2 + 32640 + 3, 2, 32640);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule